// File: doc/BRIEF.md
# Serial Flash Block-Erase Command Controller

This block is the device-side command logic of a small serial flash. It watches a mode-0 SPI slave link (active-low select, serial clock, data in, data out), all oversampled by the system clock. It decodes three commands: write-enable, read-status and block-erase. The block-erase frame is an opcode byte followed by a 24-bit address. When a valid frame is closed, the block starts a self-timed erase cycle. For the whole cycle it drives an erase request and a block index to an abstract memory-array port, and the array sets every byte of that block to FFh.

The status byte holds four fields: a busy flag for the running erase, a write-enable flag, and the two block-protect bits. The protect bits come straight from a configuration input. A host polls the status byte to see when the erase has finished. An erase is refused in four cases: the write-enable flag is clear, the select line rises anywhere other than right after the 32nd bit, a cycle is already running, or the addressed block is protected.

Top module: `bkerase_ctrl`

## Requirements
- R1: After reset, erase_req is 0, spi_miso is 0 and the status byte reads 00h.
- R2: Opcode 06h sets the write-enable flag only if the select line rises after exactly 8 bits. Opcode 05h shifts the status byte out MSB first on falling SCK edges and repeats it while select stays low. The status byte holds busy at bit 0, write-enable at bit 1 and protect[1:0] at bits 3:2, with the other bits 0.
- R3: Opcodes D8h and 52h both request a block erase. Any other opcode in a 32-bit frame starts nothing.
- R4: A block-erase frame is ignored when the write-enable flag is clear.
- R5: An erase starts only if the select line rises after exactly 32 bits. At 31, 33 or 40 bits nothing starts.
- R6: The block index is address bits 17:16. All other address bits are ignored. erase_blk holds the index, unchanged, for the whole cycle.
- R7: An accepted erase raises erase_req and the busy bit for exactly ERASE_CYCLES system clocks, then both return to 0.
- R8: The write-enable flag is cleared when the erase cycle ends.
- R9: The protect code decides which blocks are refused. Code 01 protects block 3, code 10 protects blocks 2 and 3, and code 11 protects every block. A refused erase leaves busy at 0.
- R10: While busy is 1, write-enable and block-erase frames are ignored, and read-status still works.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data into the device |
| spi_miso | output | 1 | Serial status data out of the device |
| blk_prot | input | 2 | Block-protect code shown in the status byte |
| erase_req | output | 1 | Erase request to the array, high during the cycle |
| erase_blk | output | BLK_W | Index of the block being erased |

## Verification
The assertions check the following on every cycle:
- a cycle begins only from an accepted frame with the write-enable flag set and a 32-bit count;
- no frame is accepted while busy;
- the block index stays stable during a cycle;
- the write-enable flag is down as busy falls;
- the cycle counter stays within its bound.

Only the bench scenarios show the rest:
- the exact cycle length;
- the decoding of both erase opcodes and the address bits that are ignored;
- the refusals for protection and for wrong frame lengths;
- the bit order and repetition of the status byte as it appears at the pins.

// File: rtl/bke_pkg.sv
package bke_pkg;
  localparam logic [7:0] OPC_WREN    = 8'h06;
  localparam logic [7:0] OPC_RDSR    = 8'h05;
  localparam logic [7:0] OPC_ERASE_A = 8'hD8;
  localparam logic [7:0] OPC_ERASE_B = 8'h52;

  localparam int unsigned WREN_BITS  = 8;
  localparam int unsigned ERASE_BITS = 32;

  function automatic logic is_erase_op(input logic [7:0] op);
    return (op == OPC_ERASE_A) || (op == OPC_ERASE_B);
  endfunction

  // protect code: 0 none, 1 top block, 2 top two blocks, 3 all blocks
  function automatic logic blk_locked(input logic [1:0] prot,
                                      input int unsigned blk,
                                      input int unsigned nblk);
    case (prot)
      2'd1:    return blk + 1 >= nblk;
      2'd2:    return blk + 2 >= nblk;
      2'd3:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] pack_status(input logic busy,
                                             input logic wen,
                                             input logic [1:0] prot);
    return {4'b0000, prot, wen, busy};
  endfunction
endpackage

// File: rtl/bke_spi_sync.sv
module bke_spi_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_in,
  input  logic sck_in,
  input  logic mosi_in,
  output logic sel,
  output logic sel_start,
  output logic sel_end,
  output logic sck_rise,
  output logic sck_fall,
  output logic din
);
  localparam int NLINES = 3;
  localparam int LN_CS = 0, LN_SCK = 1, LN_DI = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] synced;
  logic [NLINES-1:0] prev;

  assign raw[LN_CS]  = cs_n_in;
  assign raw[LN_SCK] = sck_in;
  assign raw[LN_DI]  = mosi_in;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [SYNC_STAGES-1:0] chain;
    // idle level: select high, clock low, data low
    localparam logic IDLE = (g == LN_CS);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain   <= {SYNC_STAGES{IDLE}};
        prev[g] <= IDLE;
      end else begin
        chain   <= {chain[SYNC_STAGES-2:0], raw[g]};
        prev[g] <= chain[SYNC_STAGES-1];
      end
    end
    assign synced[g] = chain[SYNC_STAGES-1];
  end

  assign sel       = !synced[LN_CS];
  assign sel_start = !synced[LN_CS] &&  prev[LN_CS];
  assign sel_end   =  synced[LN_CS] && !prev[LN_CS];
  assign sck_rise  =  synced[LN_SCK] && !prev[LN_SCK];
  assign sck_fall  = !synced[LN_SCK] &&  prev[LN_SCK];
  assign din       =  synced[LN_DI];
endmodule

// File: rtl/bke_frame_rx.sv
module bke_frame_rx
  import bke_pkg::*;
#(
  parameter int BLK_LSB = 16,
  parameter int BLK_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             sel_start,
  input  logic             sck_rise,
  input  logic             sck_fall,
  input  logic             din,
  input  logic [7:0]       status,
  output logic [7:0]       opcode,
  output logic             opcode_ok,
  output logic [5:0]       nbits,
  output logic [BLK_W-1:0] blk_idx,
  output logic             miso
);
  localparam int SH_W = BLK_LSB + BLK_W;
  localparam logic [5:0] NB_MAX = 6'd63;

  logic [SH_W-1:0] sh;
  logic [2:0]      bit_in_byte;
  logic            rd_mode;
  logic [7:0]      tx;
  logic [7:0]      opc_next;

  assign opc_next = {sh[6:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh          <= '0;
      bit_in_byte <= '0;
      nbits       <= '0;
      opcode      <= '0;
      opcode_ok   <= 1'b0;
      rd_mode     <= 1'b0;
      tx          <= '0;
    end else if (sel_start) begin
      bit_in_byte <= '0;
      nbits       <= '0;
      opcode_ok   <= 1'b0;
      rd_mode     <= 1'b0;
    end else if (sel) begin
      if (sck_rise) begin
        sh          <= {sh[SH_W-2:0], din};
        bit_in_byte <= bit_in_byte + 3'd1;
        if (nbits != NB_MAX) nbits <= nbits + 6'd1;
        if (nbits == 6'd7) begin
          opcode    <= opc_next;
          opcode_ok <= 1'b1;
          rd_mode   <= (opc_next == OPC_RDSR);
        end
      end else if (sck_fall && rd_mode) begin
        if (bit_in_byte == 3'd0) tx <= status;
        else                     tx <= {tx[6:0], 1'b0};
      end
    end
  end

  // sh holds address bits [SH_W-1:0] once 32 bits are in
  assign blk_idx = sh[SH_W-1:BLK_LSB];
  assign miso    = sel && rd_mode && tx[7];

  a_r2_rdmode_has_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mode |-> (opcode_ok && opcode == OPC_RDSR));
endmodule

// File: rtl/bke_erase_timer.sv
module bke_erase_timer #(
  parameter int unsigned CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign done = busy && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (done) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r7_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= LAST));
  a_r7_done_ends_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/bkerase_ctrl.sv
module bkerase_ctrl
  import bke_pkg::*;
#(
  parameter int unsigned ERASE_CYCLES = 100000,
  parameter int          SYNC_STAGES  = 2,
  parameter int          BLK_LSB      = 16,
  parameter int          BLK_W        = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_cs_n,
  input  logic             spi_sck,
  input  logic             spi_mosi,
  output logic             spi_miso,
  input  logic [1:0]       blk_prot,
  output logic             erase_req,
  output logic [BLK_W-1:0] erase_blk
);
  localparam int unsigned NBLK = 1 << BLK_W;

  logic             sel, sel_start, sel_end, sck_rise, sck_fall, din;
  logic [7:0]       opcode;
  logic             opcode_ok;
  logic [5:0]       nbits;
  logic [BLK_W-1:0] blk_idx;
  logic [7:0]       status;
  logic             busy, cycle_done;
  logic             wel_q;

  // named decision wires, visible to the assertions
  logic wren_go;
  logic erase_go;
  logic frame_is_erase;
  logic target_locked;

  bke_spi_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .cs_n_in(spi_cs_n), .sck_in(spi_sck), .mosi_in(spi_mosi),
    .sel(sel), .sel_start(sel_start), .sel_end(sel_end),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .din(din)
  );

  bke_frame_rx #(.BLK_LSB(BLK_LSB), .BLK_W(BLK_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .sel(sel), .sel_start(sel_start),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .din(din),
    .status(status),
    .opcode(opcode), .opcode_ok(opcode_ok), .nbits(nbits),
    .blk_idx(blk_idx), .miso(spi_miso)
  );

  bke_erase_timer #(.CYCLES(ERASE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .start(erase_go), .busy(busy), .done(cycle_done)
  );

  assign status         = pack_status(busy, wel_q, blk_prot);
  assign frame_is_erase = opcode_ok && is_erase_op(opcode)
                          && (nbits == 6'(ERASE_BITS));
  assign target_locked  = blk_locked(blk_prot, int'(blk_idx), NBLK);

  assign wren_go  = sel_end && !busy && opcode_ok && (opcode == OPC_WREN)
                    && (nbits == 6'(WREN_BITS));
  assign erase_go = sel_end && !busy && wel_q && frame_is_erase && !target_locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          wel_q <= 1'b0;
    else if (cycle_done) wel_q <= 1'b0;
    else if (wren_go)    wel_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        erase_blk <= '0;
    else if (erase_go) erase_blk <= blk_idx;
  end

  assign erase_req = busy;

  a_r7_cycle_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(erase_go));
  a_r4_accept_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> wel_q);
  a_r5_accept_at_32: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> (nbits == 6'd32));
  a_r10_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(erase_go || wren_go));
  a_r6_blk_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(erase_blk));
  a_r8_wel_down_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel_q);
endmodule

// File: tb/bkerase_ctrl_test.sv
`timescale 1ns/1ps
module bkerase_ctrl_test;
  localparam int unsigned CYC = 2000;
  localparam int NVEC = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, erase_req;
  logic [1:0] prot = 2'd0;
  logic [1:0] eblk;

  bkerase_ctrl #(.ERASE_CYCLES(CYC)) uut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
    .spi_mosi(mosi), .spi_miso(miso), .blk_prot(prot),
    .erase_req(erase_req), .erase_blk(eblk)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, hi_cnt = 0;
  logic [1:0] seen_blk = 2'd0;
  bit finished = 1'b0;

  always @(negedge clk) begin
    if (erase_req) begin
      hi_cnt++;
      seen_blk = eblk;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000 && !finished) begin
      fails++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // mode-0 master: half period 40 ns, send n bits MSB first, then read nrd bits
  task automatic xfer(input logic [39:0] d, input int n, input int nrd,
                      output logic [15:0] rd);
    rd = '0;
    cs_n = 1'b0; #40;
    for (int i = 0; i < n; i++) begin
      mosi = d[39-i]; #40; sck = 1'b1; #40; sck = 1'b0;
    end
    for (int j = 0; j < nrd; j++) begin
      #40; rd = {rd[14:0], miso}; sck = 1'b1; #40; sck = 1'b0;
    end
    #40; cs_n = 1'b1; mosi = 1'b0; #80;
  endtask

  task automatic read_status(output logic [15:0] r);
    xfer({8'h05, 32'h0}, 8, 16, r);
  endtask

  task automatic wren(input int n);
    logic [15:0] r;
    xfer({8'h06, 32'h0}, n, 0, r);
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  typedef struct packed {
    logic [7:0]  op;
    logic [23:0] addr;
    logic [5:0]  nb;
    logic        wen;
    logic [1:0]  bp;
    logic        go;
    logic [1:0]  blk;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{8'hD8, 24'h000000, 6'd32, 1'b1, 2'd0, 1'b1, 2'd0},  // R3 R7
    '{8'h52, 24'h01FFFF, 6'd32, 1'b1, 2'd0, 1'b1, 2'd1},  // R3 R6
    '{8'hD8, 24'h028000, 6'd32, 1'b1, 2'd0, 1'b1, 2'd2},  // R6
    '{8'h52, 24'h030001, 6'd32, 1'b1, 2'd0, 1'b1, 2'd3},  // R6
    '{8'hD8, 24'hFE1234, 6'd32, 1'b1, 2'd0, 1'b1, 2'd2},  // R6 upper bits ignored
    '{8'hD8, 24'h010000, 6'd32, 1'b0, 2'd0, 1'b0, 2'd0},  // R4 no write enable
    '{8'hD8, 24'h010000, 6'd31, 1'b1, 2'd0, 1'b0, 2'd0},  // R5
    '{8'hD8, 24'h010000, 6'd33, 1'b1, 2'd0, 1'b0, 2'd0},  // R5
    '{8'hD8, 24'h010000, 6'd40, 1'b1, 2'd0, 1'b0, 2'd0},  // R5
    '{8'hD8, 24'h030000, 6'd32, 1'b1, 2'd1, 1'b0, 2'd0},  // R9
    '{8'hD8, 24'h020000, 6'd32, 1'b1, 2'd1, 1'b1, 2'd2},  // R9
    '{8'h52, 24'h020000, 6'd32, 1'b1, 2'd2, 1'b0, 2'd0},  // R9
    '{8'h52, 24'h010000, 6'd32, 1'b1, 2'd2, 1'b1, 2'd1},  // R9
    '{8'hD8, 24'h000000, 6'd32, 1'b1, 2'd3, 1'b0, 2'd0},  // R9
    '{8'h20, 24'h000000, 6'd32, 1'b1, 2'd0, 1'b0, 2'd0}   // R3 other opcode
  };

  initial begin
    logic [15:0] r;
    #23; rst_n = 1'b1; wait_clks(5);

    // R1 reset state
    chk("R1 erase_req", {31'b0, erase_req}, 32'd0);
    chk("R1 miso", {31'b0, miso}, 32'd0);
    read_status(r);
    chk("R1 status", {16'b0, r}, 32'h0000);

    // R2 write enable with wrong length, then correct length, repeat readout
    wren(9);
    read_status(r);
    chk("R2 wren 9 bits ignored", {16'b0, r}, 32'h0000);
    prot = 2'd3;
    wren(8);
    read_status(r);
    chk("R2 status repeats", {16'b0, r}, 32'h0E0E);
    prot = 2'd0;
    wren(8);
    read_status(r);
    chk("R2 status bits", {16'b0, r}, 32'h0202);

    // vector table (WEL is already set going into vector 0)
    for (int v = 0; v < NVEC; v++) begin
      prot = VECS[v].bp;
      if (VECS[v].wen) wren(8);
      hi_cnt = 0;
      xfer({VECS[v].op, VECS[v].addr, 8'h00}, int'(VECS[v].nb), 0, r);
      wait_clks(CYC + 40);
      chk($sformatf("R7 vec%0d cycle length", v), hi_cnt, VECS[v].go ? CYC : 0);
      if (VECS[v].go)
        chk($sformatf("R6 vec%0d block", v), {30'b0, seen_blk}, {30'b0, VECS[v].blk});
      read_status(r);
      chk($sformatf("R9 vec%0d busy clear", v), {31'b0, r[8]}, 32'd0);
      if (VECS[v].go)
        chk($sformatf("R8 vec%0d wel cleared", v), {31'b0, r[9]}, 32'd0);
    end

    // R10 poll during a cycle, other commands ignored while busy
    prot = 2'd0;
    wren(8);
    hi_cnt = 0;
    xfer({8'hD8, 24'h030000, 8'h00}, 32, 0, r);
    read_status(r);
    chk("R10 busy status", {16'b0, r}, 32'h0303);
    wren(8);
    xfer({8'h52, 24'h010000, 8'h00}, 32, 0, r);
    wait_clks(CYC);
    chk("R7 single cycle", hi_cnt, CYC);
    chk("R6 first block kept", {30'b0, seen_blk}, 32'd3);
    read_status(r);
    chk("R10 wren during busy ignored", {16'b0, r}, 32'h0000);
    chk("R1 idle miso", {31'b0, miso}, 32'd0);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule